// File: doc/BRIEF.md
# Per-Revision Protection Guard

This block decides whether operations on a configuration memory may proceed. The memory holds several design revisions that are independent of one another. An upstream decoder hands the block one command per cycle. Each command is an operation code plus a revision index. The block keeps a write-lock bit, a read-shield bit and an unlock-armed flag for every revision. It answers each command one cycle later with a grant or a deny pulse. It updates the protection state when a command is honoured. The flash array itself, its timing and the test-port decoding are handled elsewhere. This block only gates and tracks permissions.

A write lock can only be removed by two commands in sequence. The first is an unlock command to the locked revision. The second is an erase of that same revision, and it must follow with no other command to that revision in between. A read shield is never removed on its own. It disappears only as a side effect of erasing the revision it covers.

A build-time parameter selects a whole-device variant. In that variant a single shared read shield covers every revision, and only a full-device erase removes it. The `secure` output is the OR of all read-shield state. It is meant for the instruction-capture logic.

Top module: `rev_guard`

## Requirements
- R1: After a synchronous active-low reset, every lock, shield and armed flag is clear. `grant`, `deny`, `lock_err` and `secure` are all 0.
- R2: The operation code on `cmd_op` is 1 for read/verify. A read is denied when the addressed revision is shielded, and granted otherwise. In the whole-device variant, "shielded" means the shared shield is set.
- R3: A read shield alone never blocks program (code 2) or erase (code 3) of that revision.
- R4: Program of a locked revision is denied. Erase of a locked revision that is not armed is also denied.
- R5: An erase refused because of a lock raises `lock_err` together with `deny` for exactly one cycle.
- R6: Unlock (code 4) arms the addressed revision. A later erase of that armed revision is granted and clears its lock, so program of it is granted afterwards.
- R7: Any command to a revision other than erase or unlock disarms that revision: read, program, lock (code 5) or read-protect (code 6). Commands to other revisions leave its armed flag alone.
- R8: In the per-revision variant, a granted erase clears that revision's read shield. Read-protect sets it. Lock and read-protect are always granted.
- R9: `secure` is 1 exactly when some read-shield state is set. It reflects a command one cycle after that command is issued.
- R10: In the whole-device variant, read-protect to any revision sets the single shared shield. An erase of a single revision leaves that shield set.
- R11: Full-device erase (code 7, `cmd_rev` ignored) is granted only when every locked revision is armed. When granted, it clears all locks, shields and armed flags. Otherwise it is denied and pulses `lock_err`.
- R12: `grant`, `deny` and `lock_err` are registered and answer the command of the previous cycle. With `cmd_valid` low, or with code 0, all three are 0 in the next cycle, and `grant` and `deny` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Operation code (0 idle, 1 read, 2 program, 3 erase, 4 unlock, 5 lock, 6 read-protect, 7 full erase) |
| cmd_rev | input | $clog2(N_REV) | Revision index addressed by the command |
| grant | output | 1 | Previous command is allowed |
| deny | output | 1 | Previous command is inhibited |
| lock_err | output | 1 | Previous erase was refused by a lock |
| secure | output | 1 | OR of all read-shield state |

## Verification
Some rules are checked on every cycle:
- `grant` and `deny` are never 1 together.
- Outputs are quiet after an idle cycle.
- `lock_err` always comes with `deny`.
- Program is decided purely by the lock bit of the addressed revision, whatever its shield.
- Reads are granted while nothing is shielded.
- `secure` holds steady across commands that cannot touch a shield.

Other behaviour depends on command history, and only the bench's scenarios can show it:
- an unlock that is lost through disarming;
- an unlock followed by an erase;
- a full erase blocked by one unarmed lock;
- a shared shield that survives a single-revision erase.

The bench runs the same stimulus on both variants.

// File: rtl/rev_guard_pkg.sv
// Shared operation codes for the per-revision protection guard.
package rev_guard_pkg;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_READ   = 3'd1,
        OP_PROG   = 3'd2,
        OP_ERASE  = 3'd3,
        OP_UNLOCK = 3'd4,
        OP_LOCK   = 3'd5,
        OP_RDPROT = 3'd6,
        OP_WIPE   = 3'd7
    } op_e;

endpackage

// File: rtl/rev_guard_decode.sv
// Command decoder.
// Turns the raw operation code and revision index into one-hot flags.
// Assumes at most one command per cycle; nothing is decoded while cmd_valid is low.
module rev_guard_decode #(
    parameter int unsigned N_REV = 4,
    parameter int unsigned REV_W = 2
) (
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [REV_W-1:0] cmd_rev,
    output logic [N_REV-1:0] rev_sel,
    output logic             is_read,
    output logic             is_prog,
    output logic             is_erase,
    output logic             is_unlock,
    output logic             is_lock,
    output logic             is_rdprot,
    output logic             is_wipe
);
    import rev_guard_pkg::*;

    op_e op;
    assign op = op_e'(cmd_op);

    // Operation flags: exactly one is high for a valid non-idle command.
    always_comb begin
        is_read   = 1'b0;
        is_prog   = 1'b0;
        is_erase  = 1'b0;
        is_unlock = 1'b0;
        is_lock   = 1'b0;
        is_rdprot = 1'b0;
        is_wipe   = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_READ:   is_read   = 1'b1;
                OP_PROG:   is_prog   = 1'b1;
                OP_ERASE:  is_erase  = 1'b1;
                OP_UNLOCK: is_unlock = 1'b1;
                OP_LOCK:   is_lock   = 1'b1;
                OP_RDPROT: is_rdprot = 1'b1;
                OP_WIPE:   is_wipe   = 1'b1;
                default:   ;
            endcase
        end
    end

    // Revision select: one-hot match of the index, gated by valid.
    for (genvar i = 0; i < N_REV; i++) begin : g_sel
        assign rev_sel[i] = cmd_valid && (cmd_rev == REV_W'(i));
    end

endmodule

// File: rtl/rev_guard_slot.sv
// State for a single revision: write lock, optional read shield, unlock-armed flag.
// Assumes the flags arrive one-hot from the decoder.
// Also assumes wipe_go is already qualified by the top (all locks armed).
module rev_guard_slot #(
    parameter bit KEEP_RP = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic is_read,
    input  logic is_prog,
    input  logic is_erase,
    input  logic is_unlock,
    input  logic is_lock,
    input  logic is_rdprot,
    input  logic wipe_go,
    output logic wp,
    output logic rp,
    output logic armed,
    output logic erase_ok
);
    logic wp_q;
    logic arm_q;

    assign erase_ok = !wp_q || arm_q;
    assign wp       = wp_q;
    assign armed    = arm_q;

    // Lock and arm tracking: unlock arms, other commands disarm, erase clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= 1'b0;
            arm_q <= 1'b0;
        end else if (wipe_go) begin
            wp_q  <= 1'b0;
            arm_q <= 1'b0;
        end else if (sel) begin
            if (is_unlock) begin
                arm_q <= 1'b1;
            end else if (is_lock) begin
                wp_q  <= 1'b1;
                arm_q <= 1'b0;
            end else if (is_erase) begin
                if (erase_ok) begin
                    wp_q  <= 1'b0;
                    arm_q <= 1'b0;
                end
            end else if (is_read || is_prog || is_rdprot) begin
                arm_q <= 1'b0;
            end
        end
    end

    if (KEEP_RP) begin : g_rp
        logic rp_q;
        // Per-revision shield: set by read-protect, cleared by a granted erase.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rp_q <= 1'b0;
            end else if (wipe_go) begin
                rp_q <= 1'b0;
            end else if (sel && is_rdprot) begin
                rp_q <= 1'b1;
            end else if (sel && is_erase && erase_ok) begin
                rp_q <= 1'b0;
            end
        end
        assign rp = rp_q;
    end else begin : g_no_rp
        assign rp = 1'b0;
    end

endmodule

// File: rtl/rev_guard_devbit.sv
// Shared read shield for the whole-device variant.
// Set by any read-protect command, cleared only by a granted full erase.
module rev_guard_devbit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic shield
);
    // Shared shield register: clear has priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shield <= 1'b0;
        end else if (clr_req) begin
            shield <= 1'b0;
        end else if (set_req) begin
            shield <= 1'b1;
        end
    end
endmodule

// File: rtl/rev_guard.sv
// Per-revision protection guard, top level.
// Decides grant or deny for each command and registers the answer.
// Keeps per-revision locks and shields, or a shared shield when DEVICE_WIDE is set.
// Assumes one command per cycle from an upstream decoder.
module rev_guard #(
    parameter int unsigned N_REV       = 4,
    parameter bit          DEVICE_WIDE = 1'b0,
    localparam int unsigned REV_W      = (N_REV > 1) ? $clog2(N_REV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [REV_W-1:0] cmd_rev,
    output logic             grant,
    output logic             deny,
    output logic             lock_err,
    output logic             secure
);
    logic [N_REV-1:0] rev_sel;
    logic is_read, is_prog, is_erase, is_unlock, is_lock, is_rdprot, is_wipe;
    logic [N_REV-1:0] wp_v, rp_v, arm_v, ok_v;
    logic all_ok, wipe_go, dev_rp;
    logic wp_sel, rp_sel, ok_sel;
    logic grant_d, deny_d, err_d;

    rev_guard_decode #(.N_REV(N_REV), .REV_W(REV_W)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_rev   (cmd_rev),
        .rev_sel   (rev_sel),
        .is_read   (is_read),
        .is_prog   (is_prog),
        .is_erase  (is_erase),
        .is_unlock (is_unlock),
        .is_lock   (is_lock),
        .is_rdprot (is_rdprot),
        .is_wipe   (is_wipe)
    );

    for (genvar i = 0; i < N_REV; i++) begin : g_slot
        rev_guard_slot #(.KEEP_RP(!DEVICE_WIDE)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (rev_sel[i]),
            .is_read   (is_read),
            .is_prog   (is_prog),
            .is_erase  (is_erase),
            .is_unlock (is_unlock),
            .is_lock   (is_lock),
            .is_rdprot (is_rdprot),
            .wipe_go   (wipe_go),
            .wp        (wp_v[i]),
            .rp        (rp_v[i]),
            .armed     (arm_v[i]),
            .erase_ok  (ok_v[i])
        );
    end

    if (DEVICE_WIDE) begin : g_dev
        rev_guard_devbit u_devbit (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (is_rdprot),
            .clr_req (wipe_go),
            .shield  (dev_rp)
        );
    end else begin : g_nodev
        assign dev_rp = 1'b0;
    end

    // A full erase may proceed only when no lock is left unarmed.
    assign all_ok  = &ok_v;
    assign wipe_go = is_wipe && all_ok;

    // Per-revision view of the addressed revision.
    assign wp_sel = wp_v[cmd_rev];
    assign ok_sel = ok_v[cmd_rev];
    assign rp_sel = DEVICE_WIDE ? dev_rp : rp_v[cmd_rev];

    // Decision table for the current command.
    always_comb begin
        grant_d = 1'b0;
        deny_d  = 1'b0;
        err_d   = 1'b0;
        if (is_read) begin
            grant_d = !rp_sel;
            deny_d  = rp_sel;
        end else if (is_prog) begin
            grant_d = !wp_sel;
            deny_d  = wp_sel;
        end else if (is_erase) begin
            grant_d = ok_sel;
            deny_d  = !ok_sel;
            err_d   = !ok_sel;
        end else if (is_unlock || is_lock || is_rdprot) begin
            grant_d = 1'b1;
        end else if (is_wipe) begin
            grant_d = all_ok;
            deny_d  = !all_ok;
            err_d   = !all_ok;
        end
    end

    // Registered answer, one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant    <= 1'b0;
            deny     <= 1'b0;
            lock_err <= 1'b0;
        end else begin
            grant    <= grant_d;
            deny     <= deny_d;
            lock_err <= err_d;
        end
    end

    // Security flag for the capture logic: any shield set anywhere.
    assign secure = (|rp_v) | dev_rp;

endmodule

// File: rtl/rev_guard_chk.sv
// Cycle-by-cycle protocol checks for rev_guard, attached with bind.
module rev_guard_chk #(
    parameter int unsigned N_REV = 4,
    parameter int unsigned REV_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [REV_W-1:0] cmd_rev,
    input logic             grant,
    input logic             deny,
    input logic             lock_err,
    input logic             secure,
    input logic [N_REV-1:0] wp_v
);
    // R12
    grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_valid) |-> (!grant && !deny && !lock_err));

    // R5
    err_with_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |-> deny);

    // R4
    prog_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && cmd_op == 3'd2 && wp_v[cmd_rev]) |-> (deny && !grant));

    // R3
    prog_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && cmd_op == 3'd2 && !wp_v[cmd_rev]) |-> grant);

    // R2
    read_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && cmd_op == 3'd1 && !secure) |-> grant);

    // R9
    secure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cmd_valid || (cmd_op inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5}))
            |-> $stable(secure));
endmodule

bind rev_guard rev_guard_chk #(.N_REV(N_REV), .REV_W(REV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_rev   (cmd_rev),
    .grant     (grant),
    .deny      (deny),
    .lock_err  (lock_err),
    .secure    (secure),
    .wp_v      (wp_v)
);

// File: tb/tb_rev_guard.sv
module tb_rev_guard;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_rev = 2'd0;
    logic g_a, d_a, e_a, s_a;
    logic g_b, d_b, e_b, s_b;

    int checks = 0;
    int errors = 0;

    // Model state: A is the per-revision variant, B is the whole-device variant.
    logic [3:0] wp_a = '0, rp_a = '0, arm_a = '0;
    logic [3:0] wp_b = '0, rp_b = '0, arm_b = '0;
    logic       drp_a = 1'b0, drp_b = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rev_guard #(.N_REV(4), .DEVICE_WIDE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rev(cmd_rev), .grant(g_a), .deny(d_a), .lock_err(e_a), .secure(s_a));

    rev_guard #(.N_REV(4), .DEVICE_WIDE(1'b1)) dut_dev (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rev(cmd_rev), .grant(g_b), .deny(d_b), .lock_err(e_b), .secure(s_b));

    // Expected answer and next state, from the requirements.
    task automatic model(input bit devm, input logic [2:0] op, input int rev,
                         inout logic [3:0] wp, inout logic [3:0] rp,
                         inout logic [3:0] arm, inout logic drp,
                         output logic g, output logic d, output logic e);
        logic rps, ok, all;
        rps = devm ? drp : rp[rev];
        ok  = !wp[rev] || arm[rev];
        all = ((wp & ~arm) == 4'b0);
        g = 1'b0; d = 1'b0; e = 1'b0;
        case (op)
            3'd1: begin g = !rps; d = rps; arm[rev] = 1'b0; end
            3'd2: begin g = !wp[rev]; d = wp[rev]; arm[rev] = 1'b0; end
            3'd3: begin
                if (ok) begin
                    g = 1'b1; wp[rev] = 1'b0; arm[rev] = 1'b0;
                    if (!devm) rp[rev] = 1'b0;
                end else begin
                    d = 1'b1; e = 1'b1;
                end
            end
            3'd4: begin g = 1'b1; arm[rev] = 1'b1; end
            3'd5: begin g = 1'b1; wp[rev] = 1'b1; arm[rev] = 1'b0; end
            3'd6: begin
                g = 1'b1; arm[rev] = 1'b0;
                if (devm) drp = 1'b1; else rp[rev] = 1'b1;
            end
            3'd7: begin
                if (all) begin
                    g = 1'b1; wp = '0; rp = '0; arm = '0; drp = 1'b0;
                end else begin
                    d = 1'b1; e = 1'b1;
                end
            end
            default: ;
        endcase
    endtask

    task automatic compare(input string tag, input string which,
                           input logic ag, input logic ad, input logic ae, input logic as,
                           input logic xg, input logic xd, input logic xe, input logic xs);
        checks++;
        if ({ag, ad, ae, as} !== {xg, xd, xe, xs}) begin
            errors++;
            $display("FAIL %s (%s): got grant=%b deny=%b err=%b secure=%b, expected grant=%b deny=%b err=%b secure=%b",
                     tag, which, ag, ad, ae, as, xg, xd, xe, xs);
        end
    endtask

    // Drive one command at a falling edge and check both variants at the next one.
    task automatic issue(input logic v, input logic [2:0] op, input logic [1:0] rev,
                         input string tag);
        logic xga, xda, xea, xgb, xdb, xeb;
        cmd_valid = v; cmd_op = op; cmd_rev = rev;
        xga = 0; xda = 0; xea = 0; xgb = 0; xdb = 0; xeb = 0;
        if (v) begin
            model(1'b0, op, int'(rev), wp_a, rp_a, arm_a, drp_a, xga, xda, xea);
            model(1'b1, op, int'(rev), wp_b, rp_b, arm_b, drp_b, xgb, xdb, xeb);
        end
        @(negedge clk);
        compare(tag, "per-rev", g_a, d_a, e_a, s_a, xga, xda, xea, (|rp_a) | drp_a);
        compare(tag, "device",  g_b, d_b, e_b, s_b, xgb, xdb, xeb, (|rp_b) | drp_b);
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd1: return "R2";
            3'd2: return "R4";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            3'd7: return "R11";
            default: return "R12";
        endcase
    endfunction

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        compare("R1", "per-rev", g_a, d_a, e_a, s_a, 0, 0, 0, 0);
        compare("R1", "device",  g_b, d_b, e_b, s_b, 0, 0, 0, 0);
        issue(1, 3'd1, 2'd0, "R1");          // default clear: read granted
        // Locks
        issue(1, 3'd5, 2'd1, "R8");          // lock rev1
        issue(1, 3'd2, 2'd1, "R4");          // program denied
        issue(1, 3'd3, 2'd1, "R5");          // erase denied with error
        issue(0, 3'd0, 2'd0, "R5");          // error lasts one cycle
        issue(1, 3'd0, 2'd2, "R12");         // idle code quiet
        // Read shields
        issue(1, 3'd6, 2'd2, "R9");          // shield rev2, secure rises
        issue(1, 3'd1, 2'd2, "R2");          // read denied
        issue(1, 3'd1, 2'd0, "R10");         // device: shared shield blocks rev0
        issue(1, 3'd2, 2'd2, "R3");          // program allowed despite shield
        issue(1, 3'd3, 2'd2, "R8");          // erase clears per-rev shield
        issue(1, 3'd1, 2'd2, "R10");         // device shield survives erase
        // Arming rules
        issue(1, 3'd4, 2'd1, "R7");          // arm rev1
        issue(1, 3'd1, 2'd1, "R7");          // read disarms
        issue(1, 3'd3, 2'd1, "R7");          // erase now refused
        issue(1, 3'd4, 2'd1, "R6");          // arm again
        issue(1, 3'd2, 2'd0, "R7");          // other revision leaves arm
        issue(1, 3'd3, 2'd1, "R6");          // erase clears lock
        issue(1, 3'd2, 2'd1, "R6");          // program now granted
        // Full erase
        issue(1, 3'd5, 2'd3, "R11");
        issue(1, 3'd6, 2'd0, "R11");
        issue(1, 3'd7, 2'd2, "R11");         // refused: rev3 unarmed
        issue(1, 3'd4, 2'd3, "R11");
        issue(1, 3'd7, 2'd0, "R11");         // granted, everything clear
        issue(1, 3'd1, 2'd0, "R10");         // device shield gone
        issue(1, 3'd2, 2'd3, "R11");
        // Constrained random traffic
        for (int i = 0; i < 600; i++) begin
            logic [2:0] op;
            logic       v;
            v  = ($urandom % 8) != 0;
            op = 3'($urandom % 7);
            if (($urandom % 20) == 0) op = 3'd7;
            issue(v, op, 2'($urandom % 4), v ? tag_of(op) : "R12");
        end
        cmd_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule